// File: doc/BRIEF.md
# Fault Alert Aggregator with Response Release

This block gathers fault sources into one active-low alert line for a host. There are three kinds of source: a set of downstream channel alert inputs, a failed-connection event, and a latched stuck-bus timeout. Each downstream alert is active-low and asynchronous, so it is synchronised before use. A channel that is currently linked to the host bus is left out, because the host already talks to the faulting device directly. The unlinked-channel faults and the connection-failure flag share one pathway. The stuck-bus timeout has a pathway of its own.

Each pathway remembers which of its fault sources the host has already acknowledged. The host acknowledges a fault in one of two ways: the device answers an alert-response read, or the host addresses the device. After that, a source that stays active does not pull the line again. A source pulls the line again when it newly becomes active, or when it goes away and later comes back. A clear pulse, taken from a write to the read-only status register, resets the connection-failure flag and forgets every acknowledgement. While the device is disabled, bus commands are ignored, but the downstream alert inputs still drive the line.

Top module: `fault_alert_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `alert_n` is 1, `conn_fail_flag` is 0 and `ch_alert_lvl` is all ones after that edge. After reset, `alert_n` is 0 exactly when some active fault source has not been acknowledged.
- R2: A low level on `ch_alert_n[i]` of an unlinked channel (`ch_linked[i]`=0) appears on `ch_alert_lvl[i]` after the second rising edge. It drives `alert_n` low after the third rising edge.
- R3: A low `ch_alert_n[i]` on a channel with `ch_linked[i]`=1 never pulls `alert_n` low.
- R4: A `conn_fail` pulse sampled with `en`=1 sets `conn_fail_flag` at that edge. It pulls `alert_n` low at the following edge.
- R5: `stuck_latched` high pulls `alert_n` low at the first edge that samples it high.
- R6: An `ara_done` or `addressed` pulse sampled with `en`=1 and `fault_clear`=0 makes `alert_n` 1 after that edge.
- R7: A source that stays active after release keeps `alert_n` high. A source that newly becomes active pulls `alert_n` low again: another channel, the connection failure, or the stuck timeout.
- R8: A released source that goes inactive and later becomes active again pulls `alert_n` low again.
- R9: A `fault_clear` pulse sampled with `en`=1 clears `conn_fail_flag` and forgets all acknowledgements. Sources still active then pull `alert_n` low at that edge. Clear wins over a release in the same cycle.
- R10: While `en`=0, `conn_fail`, `ara_done`, `addressed` and `fault_clear` are ignored and `conn_fail_flag` is held at 0. Downstream alerts still drive `alert_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Device enable; low ignores bus commands |
| ch_alert_n | input | NUM_CH | Asynchronous active-low downstream alerts |
| ch_linked | input | NUM_CH | 1 = channel currently linked to the host bus |
| conn_fail | input | 1 | Pulse: a connection attempt failed |
| stuck_latched | input | 1 | Level: latched stuck-bus timeout |
| ara_done | input | 1 | Pulse: alert-response read answered by this device |
| addressed | input | 1 | Pulse: this device was addressed |
| fault_clear | input | 1 | Pulse: write to the status register |
| alert_n | output | 1 | Active-low aggregated alert |
| conn_fail_flag | output | 1 | Sticky connection-failure status |
| ch_alert_lvl | output | NUM_CH | Synchronised downstream alert levels |

## Verification
The acknowledgement memory is internal, so its faults show up only at `alert_n`. An acknowledgement that is lost makes the line fall again on the edge right after a release, while the fault is still held. An acknowledgement that never clears stops a recurring fault from pulling the line low three edges after the input falls. An error in synchroniser depth moves every downstream assertion by a cycle, and comparing the line every clock against a reference model catches that. The enable and clear priorities are checked by issuing the commands together and reading `conn_fail_flag` and `alert_n` on the next cycle.

// File: rtl/fa_pkg.sv
// Shared types for the fault alert aggregator.
// Assumes: at most one pathway event is applied per clock.
package fa_pkg;
    // Event delivered to every alert pathway in a cycle
    typedef enum logic [1:0] {
        EVT_IDLE    = 2'd0,
        EVT_RELEASE = 2'd1,
        EVT_CLEAR   = 2'd2
    } path_evt_t;
endpackage

// File: rtl/fa_sync.sv
// Multi-stage synchroniser for a vector of asynchronous levels.
// Assumes: each bit is an independent level, so bits need not be coherent.
//          Reset loads the idle value.
module fa_sync #(
    parameter int   WIDTH    = 4,
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // First stage captures the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= {WIDTH{IDLE_VAL}};
        else        stage_q[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage retimes the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= {WIDTH{IDLE_VAL}};
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/fa_pathway.sv
// One alert pathway: keeps an acknowledgement bit per fault source.
// Raises a registered pending flag while any active source is unacknowledged.
// Assumes: faults is sampled synchronously. A source whose bit drops loses its
//          acknowledgement, so when it returns it counts as a new fault.
module fa_pathway
    import fa_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  path_evt_t        evt,
    input  logic [WIDTH-1:0] faults,
    output logic             pending
);
    logic [WIDTH-1:0] ack_q;
    logic [WIDTH-1:0] ack_next;
    logic             pend_q;

    // Next acknowledgement set: forget on clear, keep only active, add on release
    always_comb begin
        unique case (evt)
            EVT_CLEAR:   ack_next = '0;
            EVT_RELEASE: ack_next = faults;
            default:     ack_next = ack_q & faults;
        endcase
    end

    // Acknowledgement memory and the registered pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            ack_q  <= ack_next;
            pend_q <= |(faults & ~ack_next);
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/fault_alert_ctrl.sv
// Top: combines the downstream alerts, the connection failure and the stuck-bus
// timeout into one active-low alert.
// Assumes: conn_fail, ara_done, addressed and fault_clear are one-cycle pulses
//          synchronous to clk. ch_linked and stuck_latched are synchronous levels.
module fault_alert_ctrl
    import fa_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [NUM_CH-1:0] ch_alert_n,
    input  logic [NUM_CH-1:0] ch_linked,
    input  logic              conn_fail,
    input  logic              stuck_latched,
    input  logic              ara_done,
    input  logic              addressed,
    input  logic              fault_clear,
    output logic              alert_n,
    output logic              conn_fail_flag,
    output logic [NUM_CH-1:0] ch_alert_lvl
);
    localparam int SHARED_W = NUM_CH + 1;

    logic [NUM_CH-1:0]   ch_sync;
    logic                fail_q;
    logic [SHARED_W-1:0] shared_src;
    path_evt_t           evt;
    logic                pend_shared;
    logic                pend_stuck;

    fa_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ch_alert_n),
        .q_sync  (ch_sync)
    );

    // Sticky connection-failure flag; reset to default while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   fail_q <= 1'b0;
        else if (fault_clear) fail_q <= 1'b0;
        else if (conn_fail)   fail_q <= 1'b1;
    end

    // Shared sources: unlinked low channels plus the failure flag on top
    assign shared_src = {fail_q, ~ch_sync & ~ch_linked};

    // Command decode: disabled ignores all, clear outranks release
    always_comb begin
        if (!en)                         evt = EVT_IDLE;
        else if (fault_clear)            evt = EVT_CLEAR;
        else if (ara_done || addressed)  evt = EVT_RELEASE;
        else                             evt = EVT_IDLE;
    end

    fa_pathway #(.WIDTH(SHARED_W)) u_path_shared (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .faults  (shared_src),
        .pending (pend_shared)
    );

    fa_pathway #(.WIDTH(1)) u_path_stuck (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .faults  (stuck_latched),
        .pending (pend_stuck)
    );

    assign alert_n        = ~(pend_shared | pend_stuck);
    assign conn_fail_flag = fail_q;
    assign ch_alert_lvl   = ch_sync;
endmodule

// File: rtl/fa_alert_chk.sv
// Checker for fault_alert_ctrl, attached by bind below.
// Assumes: it is connected to top ports and to the internal shared source vector.
module fa_alert_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              conn_fail,
    input logic              stuck_latched,
    input logic              ara_done,
    input logic              addressed,
    input logic              fault_clear,
    input logic              alert_n,
    input logic              conn_fail_flag,
    input logic [NUM_CH:0]   shared_src
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (alert_n && !conn_fail_flag));

    assert_fall_needs_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n) |-> $past((|shared_src) || stuck_latched));

    assert_fail_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && conn_fail && !fault_clear) |=> conn_fail_flag);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (ara_done || addressed) && !fault_clear) |=> alert_n);

    assert_clear_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fault_clear) |=> !conn_fail_flag);

    assert_disabled_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !conn_fail_flag);
endmodule

bind fault_alert_ctrl fa_alert_chk #(.NUM_CH(NUM_CH)) u_fa_alert_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .conn_fail      (conn_fail),
    .stuck_latched  (stuck_latched),
    .ara_done       (ara_done),
    .addressed      (addressed),
    .fault_clear    (fault_clear),
    .alert_n        (alert_n),
    .conn_fail_flag (conn_fail_flag),
    .shared_src     (shared_src)
);

// File: tb/test_fault_alert_ctrl.sv
module test_fault_alert_ctrl;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b1;
    logic [NCH-1:0] ch_alert_n = '1;
    logic [NCH-1:0] ch_linked = '0;
    logic           conn_fail = 1'b0;
    logic           stuck_latched = 1'b0;
    logic           ara_done = 1'b0;
    logic           addressed = 1'b0;
    logic           fault_clear = 1'b0;
    logic           alert_n;
    logic           conn_fail_flag;
    logic [NCH-1:0] ch_alert_lvl;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fault_alert_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(2)) i_fault_alert_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .ch_alert_n(ch_alert_n),
        .ch_linked(ch_linked), .conn_fail(conn_fail), .stuck_latched(stuck_latched),
        .ara_done(ara_done), .addressed(addressed), .fault_clear(fault_clear),
        .alert_n(alert_n), .conn_fail_flag(conn_fail_flag), .ch_alert_lvl(ch_alert_lvl)
    );

    // Behavioural reference: delay queue for sync, announced bit per source
    bit m_dly1[NCH], m_dly2[NCH];
    bit m_seen[NCH+2];
    bit m_fail, m_alert_n;

    always @(posedge clk) begin
        bit active[NCH+2];
        bit any_new;
        bit rel, clr;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin m_dly1[i] = 1; m_dly2[i] = 1; end
            for (int j = 0; j < NCH+2; j++) m_seen[j] = 0;
            m_fail = 0; m_alert_n = 1;
        end else begin
            for (int i = 0; i < NCH; i++) active[i] = !m_dly2[i] && !ch_linked[i];
            active[NCH]   = m_fail;
            active[NCH+1] = stuck_latched;
            clr = en && fault_clear;
            rel = en && !fault_clear && (ara_done || addressed);
            any_new = 0;
            for (int j = 0; j < NCH+2; j++) begin
                if (clr || !active[j]) m_seen[j] = 0;
                else if (rel)          m_seen[j] = 1;
                if (active[j] && !m_seen[j]) any_new = 1;
            end
            m_alert_n = !any_new;
            if (!en || fault_clear) m_fail = 0;
            else if (conn_fail)     m_fail = 1;
            for (int i = 0; i < NCH; i++) begin m_dly2[i] = m_dly1[i]; m_dly1[i] = ch_alert_n[i]; end
        end
    end

    task automatic check(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R1 covers the overall function)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 model alert_n", alert_n, m_alert_n);
            check("R4 model conn_fail_flag", conn_fail_flag, m_fail);
            for (int i = 0; i < NCH; i++) check("R2 model ch_alert_lvl", ch_alert_lvl[i], m_dly2[i]);
        end
    end

    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic pulse_release(bit use_addr);
        if (use_addr) addressed = 1; else ara_done = 1;
        step();
        addressed = 0; ara_done = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); step(3);
        check("R1 reset alert_n", alert_n, 1'b1);
        check("R1 reset flag", conn_fail_flag, 1'b0);
        check("R1 reset lvl", &ch_alert_lvl, 1'b1);
        rst_n = 1;
        step(2);
        check("R1 idle", alert_n, 1'b1);

        // R2: channel 0 low, unlinked
        ch_alert_n[0] = 0;
        step(2);
        check("R2 lvl after two edges", ch_alert_lvl[0], 1'b0);
        check("R2 alert still high", alert_n, 1'b1);
        step();
        check("R2 alert after three edges", alert_n, 1'b0);

        // R6: response read releases
        pulse_release(0);
        check("R6 release by response read", alert_n, 1'b1);
        step(5);
        check("R7 held fault stays released", alert_n, 1'b1);

        // R7: new channel fault re-asserts
        ch_alert_n[1] = 0;
        step(3);
        check("R7 new channel reasserts", alert_n, 1'b0);
        pulse_release(1);
        check("R6 release by addressing", alert_n, 1'b1);

        // R3: linked channel ignored
        ch_linked[2] = 1; ch_alert_n[2] = 0;
        step(6);
        check("R3 linked channel ignored", alert_n, 1'b1);

        // R8: channel 1 recovers then recurs
        ch_alert_n[1] = 1; step(4);
        check("R8 recovered quiet", alert_n, 1'b1);
        ch_alert_n[1] = 0; step(3);
        check("R8 recurrence reasserts", alert_n, 1'b0);
        pulse_release(0);

        // R5: stuck timeout on own pathway
        stuck_latched = 1; step();
        check("R5 stuck asserts", alert_n, 1'b0);
        pulse_release(1);
        check("R5 stuck released", alert_n, 1'b1);

        // R4: connection failure
        conn_fail = 1; step(); conn_fail = 0;
        check("R4 flag set", conn_fail_flag, 1'b1);
        check("R4 alert not yet", alert_n, 1'b1);
        step();
        check("R4 alert low", alert_n, 1'b0);
        pulse_release(0);
        check("R7 released all", alert_n, 1'b1);

        // R9: clear beats release, faults still active reassert
        fault_clear = 1; ara_done = 1; step(); fault_clear = 0; ara_done = 0;
        check("R9 flag cleared", conn_fail_flag, 1'b0);
        check("R9 active faults reassert", alert_n, 1'b0);
        pulse_release(0);
        stuck_latched = 0;
        for (int i = 0; i < NCH; i++) ch_alert_n[i] = 1;
        ch_linked = '0;
        step(4);
        check("R9 quiet after recovery", alert_n, 1'b1);

        // R10: disabled ignores commands but monitors alerts
        en = 0;
        conn_fail = 1; step(); conn_fail = 0;
        check("R10 conn_fail ignored", conn_fail_flag, 1'b0);
        step();
        check("R10 no alert from conn_fail", alert_n, 1'b1);
        ch_alert_n[3] = 0; step(3);
        check("R10 alert while disabled", alert_n, 1'b0);
        pulse_release(0);
        check("R10 release ignored", alert_n, 1'b0);
        en = 1;
        pulse_release(1);
        check("R6 release after enable", alert_n, 1'b1);
        ch_alert_n[3] = 1; step(4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule